// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial port that a CPU drives through four byte-wide registers. The CPU writes a character into a one-deep transmit holding register and reads a received character from a one-deep receive buffer. It polls a status byte to find out whether the transmitter can take another character and whether a received character is waiting, together with any error found while receiving it.

The frame format can be set at run time. A divisor sets the rate of a 16x oversampling tick. Data length can be 5 to 8 bits. Parity can be off, even or odd. The stop period can be 1, 1.5 or 2 bit times. The transmitter serializes each character as a low start bit, then the data bits least significant first, then the optional parity bit, then the high stop period. The receiver waits for a falling edge. It checks the start bit at its midpoint, samples each later bit at tick 8 of its 16-tick period, and posts the character at the midpoint of the first stop bit.

Top module: `uart_xcvr`

## Requirements
- R1: The line idles high. A transmitted frame is one low start bit, then the data bits with bit 0 first, then the parity bit if enabled, then a high stop period.
- R2: The divisor register (address 2, reset 0) makes one oversampling tick every divisor+1 clocks, and each bit lasts 16 ticks. Transmitter and receiver both follow this rate.
- R3: Format field bits [1:0] of address 3 select a data length of 5 + value. In a received character, the bits above the data length read as zero.
- R4: Format bit 2 enables parity. Format bit 3 set selects even parity, where the data bits plus the parity bit hold an even number of ones. Bit 3 clear selects odd parity.
- R5: Format bits [5:4] set the stop period: 0 gives 16 ticks, 1 gives 24 ticks, and 2 or 3 gives 32 ticks. A character waiting in the holding register starts right after the stop period ends.
- R6: A received parity bit that does not match the selected sense sets status bit 2 (parity error).
- R7: A stop bit that samples low at its midpoint sets status bit 3 (framing error). The character is still posted.
- R8: If a character completes while status bit 1 (receive ready) is still set and the buffer is not being read, status bit 4 (overrun) is set and the newer character replaces the older one.
- R9: Reading address 0 returns the received character and clears status bits 1 to 4.
- R10: Writing address 0 while status bit 0 (holding empty) is set stores the character and clears bit 0. Bit 0 sets again when the shifter takes the character. A write made while bit 0 is clear is dropped.
- R11: A low pulse that is high again at the start bit's midpoint (tick 8) is discarded and posts nothing.
- R12: Address 1 reads the status byte {000, overrun, framing, parity, rx ready, tx holding empty}. After reset the status is 0x01, the format reads 0x03 (8 data bits, no parity, 1 stop bit), and the line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_addr_i | input | 2 | Register address: 0 data, 1 status, 2 divisor, 3 format |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (side effects on address 0) |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the addressed register |
| rxd_i | input | 1 | Serial receive line (asynchronous) |
| txd_o | output | 1 | Serial transmit line |

## Verification
The hardest condition to reach from the ports is a write that arrives in the one cycle between the holding register filling and the shifter taking the character. The bench reaches it by holding the write strobe over two consecutive edges with different data. It then confirms that only the first character appears on the line.

The other conditions that need deliberate stimulus are overrun, framing, parity and false-start errors. The bench's own serial driver produces them by sending two characters with no read in between, driving a low stop bit, flipping the parity bit, and sending a low pulse shorter than half a bit.

Stop length is measured on the line as the idle gap between back-to-back frames, and the gap is compared against the selected stop period.

// File: rtl/uart_pkg.sv
package uart_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } frame_st_e;

  typedef struct packed {
    logic [1:0] stop;
    logic       even;
    logic       par_en;
    logic [1:0] len;
  } fmt_t;

  function automatic logic [3:0] nbits(input logic [1:0] c);
    return 4'd5 + {2'b00, c};
  endfunction

  function automatic logic [5:0] stop_ticks(input logic [1:0] c);
    case (c)
      2'd0:    return 6'd16;
      2'd1:    return 6'd24;
      default: return 6'd32;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] len_mask(input logic [1:0] c);
    return {DATA_W{1'b1}} >> (2'd3 - c);
  endfunction
endpackage

// File: rtl/uart_baud.sv
module uart_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             restart_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (restart_i || tick_o) cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/uart_tx.sv
module uart_tx
  import uart_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  fmt_t              fmt_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              take_o,
  output logic              busy_o,
  output logic              txd_o
);
  frame_st_e         st_q;
  logic [5:0]        tcnt_q;
  logic [2:0]        bidx_q;
  logic [DATA_W-1:0] sh_q;
  logic              par_q;
  logic [5:0]        last_c;

  assign take_o = (st_q == ST_IDLE) && load_i;
  assign busy_o = (st_q != ST_IDLE);
  assign last_c = (st_q == ST_STOP) ? stop_ticks(fmt_i.stop) - 6'd1 : 6'd15;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      tcnt_q <= '0;
      bidx_q <= '0;
      sh_q   <= '0;
      par_q  <= 1'b0;
    end else if (st_q == ST_IDLE) begin
      if (load_i) begin
        st_q   <= ST_START;
        tcnt_q <= '0;
        sh_q   <= data_i;
        // even: ones in data; odd: inverted
        par_q  <= (^(data_i & len_mask(fmt_i.len))) ^ ~fmt_i.even;
      end
    end else if (tick_i) begin
      if (tcnt_q == last_c) begin
        tcnt_q <= '0;
        unique case (st_q)
          ST_START: begin
            st_q   <= ST_DATA;
            bidx_q <= '0;
          end
          ST_DATA: begin
            sh_q <= sh_q >> 1;
            if ({1'b0, bidx_q} == nbits(fmt_i.len) - 4'd1)
              st_q <= fmt_i.par_en ? ST_PAR : ST_STOP;
            else
              bidx_q <= bidx_q + 3'd1;
          end
          ST_PAR:  st_q <= ST_STOP;
          default: st_q <= ST_IDLE;
        endcase
      end else begin
        tcnt_q <= tcnt_q + 6'd1;
      end
    end
  end

  always_comb begin
    unique case (st_q)
      ST_START: txd_o = 1'b0;
      ST_DATA:  txd_o = sh_q[0];
      ST_PAR:   txd_o = par_q;
      default:  txd_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  fmt_t              fmt_i,
  input  logic              rxd_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              perr_o,
  output logic              ferr_o
);
  frame_st_e         st_q;
  logic [1:0]        sync_q;
  logic              prev_q;
  logic [3:0]        tcnt_q;
  logic [2:0]        bidx_q;
  logic [DATA_W-1:0] sh_q;
  logic              par_q;
  logic              rx_s, mid, fin;
  logic [DATA_W-1:0] aligned;

  assign rx_s    = sync_q[1];
  assign mid     = tick_i && (tcnt_q == 4'd7);
  assign fin     = tick_i && (tcnt_q == 4'd15);
  assign aligned = sh_q >> (4'd8 - nbits(fmt_i.len));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], rxd_i};
      prev_q <= rx_s;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      tcnt_q <= '0;
      bidx_q <= '0;
      sh_q   <= '0;
      par_q  <= 1'b0;
      done_o <= 1'b0;
      data_o <= '0;
      perr_o <= 1'b0;
      ferr_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (st_q == ST_IDLE) begin
        if (prev_q && !rx_s) begin
          st_q   <= ST_START;
          tcnt_q <= '0;
        end
      end else if (tick_i) begin
        tcnt_q <= tcnt_q + 4'd1;
        unique case (st_q)
          ST_START: begin
            if (mid && rx_s) st_q <= ST_IDLE;   // false start
            else if (fin) begin
              st_q   <= ST_DATA;
              bidx_q <= '0;
            end
          end
          ST_DATA: begin
            if (mid) sh_q <= {rx_s, sh_q[DATA_W-1:1]};
            if (fin) begin
              if ({1'b0, bidx_q} == nbits(fmt_i.len) - 4'd1)
                st_q <= fmt_i.par_en ? ST_PAR : ST_STOP;
              else
                bidx_q <= bidx_q + 3'd1;
            end
          end
          ST_PAR: begin
            if (mid) par_q <= rx_s;
            if (fin) st_q <= ST_STOP;
          end
          default: begin
            if (mid) begin
              done_o <= 1'b1;
              data_o <= aligned;
              perr_o <= fmt_i.par_en && (((^aligned) ^ ~fmt_i.even) != par_q);
              ferr_o <= !rx_s;
              st_q   <= ST_IDLE;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_xcvr.sv
module uart_xcvr
  import uart_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              rxd_i,
  output logic              txd_o
);
  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DIV  = 2'd2;
  localparam logic [1:0] A_FMT  = 2'd3;
  localparam fmt_t       FMT_RST = '{stop: 2'd0, even: 1'b0, par_en: 1'b0, len: 2'd3};

  logic [DIV_W-1:0]  div_q;
  fmt_t              fmt_q;
  logic [DATA_W-1:0] thr_q, rbr_q;
  logic              thr_empty_q, rx_ready_q, perr_q, ferr_q, ovr_q;
  logic              tick, tx_take, tx_busy;
  logic              rx_done, rx_perr, rx_ferr;
  logic [DATA_W-1:0] rx_data;
  logic              wr_data, rd_clr;

  assign wr_data = reg_wr_i && (reg_addr_i == A_DATA);
  assign rd_clr  = reg_rd_i && (reg_addr_i == A_DATA);

  uart_baud #(.DIV_W(DIV_W)) u_baud (
    .clk_i, .rst_ni, .div_i(div_q),
    .restart_i(reg_wr_i && (reg_addr_i == A_DIV)), .tick_o(tick)
  );

  uart_tx u_tx (
    .clk_i, .rst_ni, .tick_i(tick), .fmt_i(fmt_q),
    .load_i(!thr_empty_q), .data_i(thr_q),
    .take_o(tx_take), .busy_o(tx_busy), .txd_o
  );

  uart_rx u_rx (
    .clk_i, .rst_ni, .tick_i(tick), .fmt_i(fmt_q), .rxd_i,
    .done_o(rx_done), .data_o(rx_data), .perr_o(rx_perr), .ferr_o(rx_ferr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      fmt_q <= FMT_RST;
    end else if (reg_wr_i) begin
      if (reg_addr_i == A_DIV) div_q <= reg_wdata_i[DIV_W-1:0];
      if (reg_addr_i == A_FMT) fmt_q <= reg_wdata_i[5:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q       <= '0;
      thr_empty_q <= 1'b1;
    end else if (wr_data && thr_empty_q) begin
      thr_q       <= reg_wdata_i;
      thr_empty_q <= 1'b0;
    end else if (tx_take) begin
      thr_empty_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbr_q      <= '0;
      rx_ready_q <= 1'b0;
      perr_q     <= 1'b0;
      ferr_q     <= 1'b0;
      ovr_q      <= 1'b0;
    end else if (rx_done) begin
      rbr_q      <= rx_data;
      rx_ready_q <= 1'b1;
      ovr_q      <= (ovr_q || rx_ready_q) && !rd_clr;
      perr_q     <= (perr_q && !rd_clr) || rx_perr;
      ferr_q     <= (ferr_q && !rd_clr) || rx_ferr;
    end else if (rd_clr) begin
      rx_ready_q <= 1'b0;
      perr_q     <= 1'b0;
      ferr_q     <= 1'b0;
      ovr_q      <= 1'b0;
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      A_DATA:  reg_rdata_o = rbr_q;
      A_STAT:  reg_rdata_o = {3'b000, ovr_q, ferr_q, perr_q, rx_ready_q, thr_empty_q};
      A_DIV:   reg_rdata_o = DATA_W'(div_q);
      default: reg_rdata_o = {2'b00, fmt_q};
    endcase
  end
endmodule

// File: rtl/uart_xcvr_chk.sv
module uart_xcvr_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] reg_addr_i,
  input logic       reg_wr_i,
  input logic       reg_rd_i,
  input logic [7:0] reg_rdata_o,
  input logic       txd_o,
  input logic       tx_busy,
  input logic       thr_empty_q,
  input logic [7:0] thr_q,
  input logic       rx_done,
  input logic [7:0] rx_data,
  input logic       rx_ready_q,
  input logic       perr_q,
  input logic       ferr_q,
  input logic       ovr_q,
  input logic [5:0] fmt_q
);
  // R1
  idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_busy |-> txd_o);

  // R3
  len5_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done && fmt_q[1:0] == 2'd0) |-> (rx_data[7:5] == 3'b000));

  // R8
  overrun_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done && rx_ready_q && !(reg_rd_i && reg_addr_i == 2'd0)) |=> ovr_q);

  // R9
  read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i == 2'd0 && !rx_done) |=>
      (!rx_ready_q && !perr_q && !ferr_q && !ovr_q));

  // R10
  full_write_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == 2'd0 && !thr_empty_q) |=> $stable(thr_q));

  // R12
  status_rsv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == 2'd1) |-> (reg_rdata_o[7:5] == 3'b000));
endmodule

bind uart_xcvr uart_xcvr_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_addr_i(reg_addr_i), .reg_wr_i(reg_wr_i),
  .reg_rd_i(reg_rd_i), .reg_rdata_o(reg_rdata_o), .txd_o(txd_o), .tx_busy(tx_busy),
  .thr_empty_q(thr_empty_q), .thr_q(thr_q), .rx_done(rx_done), .rx_data(rx_data),
  .rx_ready_q(rx_ready_q), .perr_q(perr_q), .ferr_q(ferr_q), .ovr_q(ovr_q),
  .fmt_q(fmt_q)
);

// File: tb/uart_xcvr_bench.sv
module uart_xcvr_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = 2'd1;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       rxd = 1'b1;
  logic       txd;

  int checks = 0, errors = 0;
  bit finished = 0;
  int cfg_div = 0, cfg_len = 8, cfg_stop = 16;
  bit cfg_par = 0, cfg_even = 0;
  logic [7:0] tx_exp[$];
  int frames_seen = 0;
  int last_gap = 0;

  always #10 clk = ~clk;

  uart_xcvr u_uart_xcvr (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .rxd_i(rxd), .txd_o(txd)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0; addr = 2'd1;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [7:0] d, input bit side);
    @(negedge clk); addr = a; rd = side; #1 d = rdata;
    @(negedge clk); rd = 1'b0; addr = 2'd1;
  endtask

  task automatic set_fmt(input int div, input int len, input bit pe, input bit ev, input int stop);
    logic [1:0] sc;
    sc = (stop == 16) ? 2'd0 : (stop == 24) ? 2'd1 : 2'd2;
    cfg_div = div; cfg_len = len; cfg_par = pe; cfg_even = ev; cfg_stop = stop;
    reg_wr(2'd2, 8'(div));
    reg_wr(2'd3, {2'b00, sc, ev, pe, 2'(len - 5)});
  endtask

  function automatic bit par_of(input logic [7:0] d, input int len, input bit ev);
    bit p = 0;
    for (int i = 0; i < len; i++) p ^= d[i];
    return ev ? p : ~p;
  endfunction

  // transmit-line model: decodes frames by midpoint sampling, checks against queue
  initial begin
    bit prev = 1;
    int gap = 0;
    forever begin
      @(negedge clk);
      if (prev && !txd) begin
        int bt;
        logic [7:0] v;
        bt = (cfg_div + 1) * 16;
        last_gap = gap;
        v = 8'h00;
        repeat (bt / 2) @(negedge clk);
        chk(txd == 1'b0, "R1 start bit low", txd, 0);
        for (int i = 0; i < cfg_len; i++) begin
          repeat (bt) @(negedge clk);
          v[i] = txd;
        end
        if (cfg_par) begin
          repeat (bt) @(negedge clk);
          chk(txd == par_of(v, cfg_len, cfg_even), "R4 parity bit", txd, par_of(v, cfg_len, cfg_even));
        end
        repeat (bt) @(negedge clk);
        chk(txd == 1'b1, "R1 stop bit high", txd, 1);
        if (tx_exp.size() == 0) chk(0, "R10 unexpected frame", v, 0);
        else begin
          logic [7:0] e;
          e = tx_exp.pop_front();
          chk(v == e, "R1/R2 tx data", v, e);
        end
        frames_seen++;
        gap = 0;
        prev = txd;
      end else begin
        gap++;
        prev = txd;
      end
    end
  end

  task automatic wait_frames(input int n);
    int g = 0;
    while (frames_seen < n && g < 20000) begin @(negedge clk); g++; end
  endtask

  task automatic send_rx(input logic [7:0] d, input bit bad_par, input bit bad_stop);
    int bt;
    bt = (cfg_div + 1) * 16;
    @(negedge clk);
    rxd = 1'b0; repeat (bt) @(negedge clk);
    for (int i = 0; i < cfg_len; i++) begin rxd = d[i]; repeat (bt) @(negedge clk); end
    if (cfg_par) begin rxd = par_of(d, cfg_len, cfg_even) ^ bad_par; repeat (bt) @(negedge clk); end
    rxd = !bad_stop; repeat (bt * cfg_stop / 16) @(negedge clk);
    rxd = 1'b1; repeat (bt) @(negedge clk);
  endtask

  task automatic check_gap(input string req);
    int exp, diff;
    exp = (cfg_stop - 8) * (cfg_div + 1);
    diff = last_gap - exp;
    chk(diff >= -(cfg_div + 3) && diff <= cfg_div + 3, req, last_gap, exp);
  endtask

  task automatic tx_pair(input logic [7:0] a, input logic [7:0] b, input string req);
    logic [7:0] s;
    int base;
    base = frames_seen;
    tx_exp.push_back(a); tx_exp.push_back(b);
    reg_wr(2'd0, a);
    repeat (40) @(negedge clk);
    reg_wr(2'd0, b);
    reg_rd(2'd1, s, 0);
    chk(s[0] == 1'b0, "R10 holding full while shifter busy", s, 0);
    wait_frames(base + 2);
    chk(frames_seen == base + 2, "R1 frames seen", frames_seen, base + 2);
    check_gap(req);
    repeat (200) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    reg_rd(2'd1, v, 0); chk(v == 8'h01, "R12 reset status", v, 8'h01);
    reg_rd(2'd3, v, 0); chk(v == 8'h03, "R12 reset format", v, 8'h03);
    reg_rd(2'd2, v, 0); chk(v == 8'h00, "R2 reset divisor", v, 0);
    chk(txd == 1'b1, "R12 reset line high", txd, 1);

    // R2 fastest rate, 8N1
    set_fmt(0, 8, 0, 0, 16);
    tx_pair(8'hA5, 8'h3C, "R5 stop 1 bit gap (div 0)");

    // R5 stop lengths at divisor 3
    set_fmt(3, 8, 0, 0, 16);
    tx_pair(8'h81, 8'h7E, "R5 stop 1 bit gap");
    set_fmt(3, 6, 0, 0, 24);
    tx_pair(8'h2A, 8'h15, "R5 stop 1.5 bit gap");
    set_fmt(3, 7, 1, 1, 32);
    tx_pair(8'h55, 8'h6B, "R5 stop 2 bit gap");
    // R4 odd parity, 5 bits
    set_fmt(3, 5, 1, 0, 16);
    tx_pair(8'h13, 8'h0F, "R5 stop gap with odd parity");

    // R10 write in the cycle before load is dropped
    set_fmt(3, 8, 0, 0, 16);
    base = frames_seen;
    tx_exp.push_back(8'hC3);
    @(negedge clk); addr = 2'd0; wdata = 8'hC3; wr = 1'b1;
    @(negedge clk); wdata = 8'h99;
    @(negedge clk); wr = 1'b0; addr = 2'd1; #1;
    chk(rdata[0] == 1'b1, "R10 holding empty after load", rdata, 1);
    repeat (3000) @(negedge clk);
    chk(frames_seen == base + 1, "R10 dropped write sends nothing", frames_seen, base + 1);
    chk(tx_exp.size() == 0, "R10 expected frames consumed", tx_exp.size(), 0);

    // R1/R9 receive 8N1
    send_rx(8'hB4, 0, 0);
    reg_rd(2'd1, v, 0); chk(v == 8'h03, "R9 rx ready status", v, 8'h03);
    reg_rd(2'd0, v, 1); chk(v == 8'hB4, "R1 rx data", v, 8'hB4);
    reg_rd(2'd1, v, 0); chk(v == 8'h01, "R9 read clears ready", v, 8'h01);

    // R3 5-bit receive, upper bits zero
    set_fmt(3, 5, 0, 0, 16);
    send_rx(8'hF5, 0, 0);
    reg_rd(2'd0, v, 1); chk(v == 8'h15, "R3 5-bit rx upper zero", v, 8'h15);

    // R6 parity error, 7E1
    set_fmt(3, 7, 1, 1, 16);
    send_rx(8'h55, 0, 0);
    reg_rd(2'd1, v, 0); chk(v == 8'h03, "R6 good parity no error", v, 8'h03);
    reg_rd(2'd0, v, 1); chk(v == 8'h55, "R4 rx data with parity", v, 8'h55);
    send_rx(8'h55, 1, 0);
    reg_rd(2'd1, v, 0); chk(v == 8'h07, "R6 parity error flag", v, 8'h07);
    reg_rd(2'd0, v, 1);
    reg_rd(2'd1, v, 0); chk(v == 8'h01, "R9 read clears parity error", v, 8'h01);

    // R7 framing error
    set_fmt(3, 8, 0, 0, 16);
    send_rx(8'h5A, 0, 1);
    reg_rd(2'd1, v, 0); chk(v == 8'h0B, "R7 framing error flag", v, 8'h0B);
    reg_rd(2'd0, v, 1); chk(v == 8'h5A, "R7 char still posted", v, 8'h5A);

    // R8 overrun
    send_rx(8'h11, 0, 0);
    send_rx(8'h22, 0, 0);
    reg_rd(2'd1, v, 0); chk(v == 8'h13, "R8 overrun flag", v, 8'h13);
    reg_rd(2'd0, v, 1); chk(v == 8'h22, "R8 newest char kept", v, 8'h22);
    reg_rd(2'd1, v, 0); chk(v == 8'h01, "R9 read clears overrun", v, 8'h01);

    // R11 false start rejected
    @(negedge clk); rxd = 1'b0;
    repeat (5 * (cfg_div + 1)) @(negedge clk);
    rxd = 1'b1;
    repeat (40 * (cfg_div + 1)) @(negedge clk);
    reg_rd(2'd1, v, 0); chk(v == 8'h01, "R11 glitch posts nothing", v, 8'h01);
    send_rx(8'hE7, 0, 0);
    reg_rd(2'd0, v, 1); chk(v == 8'hE7, "R11 next char after glitch", v, 8'hE7);

    // R2 receive at divisor 0
    set_fmt(0, 8, 1, 0, 16);
    send_rx(8'h6D, 0, 0);
    reg_rd(2'd1, v, 0); chk(v == 8'h03, "R2 rx status at div 0", v, 8'h03);
    reg_rd(2'd0, v, 1); chk(v == 8'h6D, "R2 rx data at div 0", v, 8'h6D);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=0x0 expected=0x1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule